// File: doc/BRIEF.md
# Deterministic Scan-Execute Cycle Sequencer

This block is the controller for a fixed acquisition-and-control cycle. A base trigger starts a cycle, and the cycle then runs its phases in one fixed order. First an input scan. Then a scan-status check, which is run only when status variables are in use. Then a timed window in which held variable changes are applied. Then the enabled algorithm slots, one after another in ascending index. Last, an output write. The scan hardware, the algorithm engine and the output drivers are outside the block. The sequencer gives each of them a one-clock start strobe and waits for its done input before it moves on.

The status check and the update window have no handshake and are timed inside the block. The check lasts a base number of clock ticks plus a fixed number of ticks for each referenced status variable. The window lasts a programmed number of cycles. A trigger that arrives while a cycle is running does not start another cycle. It sets a sticky overrun flag instead, and software clears that flag with a write-one-to-clear input.

Top module: `scan_cycle_seq`

## Requirements
- R1: While reset is low, and in the first cycle after reset, busy_o, overrun_o and every start strobe are 0.
- R2: A trig_i sampled while idle raises busy_o and pulses scan_start_o on the same clock edge. No more than one start strobe is ever high in any cycle.
- R3: The scan phase lasts until scan_done_i is sampled. When status_vars_i is 0, the check phase is skipped and update_start_o pulses on that same edge.
- R4: When status_vars_i = n is nonzero, verify_start_o pulses on the edge that samples scan_done_i. The check lasts exactly VERIFY_BASE + VERIFY_PER_VAR*n cycles, and update_start_o follows after that many cycles.
- R5: The update window lasts win_len_i cycles, where 0 counts as 1. The first alg_start_o or out_start_o follows after that many cycles.
- R6: Slots are started in strictly ascending index order. Each later start comes on the edge that samples alg_done_i.
- R7: Bit k of alg_mask_i enables the slot reported as alg_idx_o = k. A disabled slot never gets alg_start_o.
- R8: When alg_mask_i is all zeros, out_start_o follows the update window directly.
- R9: The cycle ends on the edge that samples out_done_i, and busy_o is 0 from the next cycle on.
- R10: A trig_i sampled while busy does not start a scan and sets overrun_o. overrun_o stays set until overrun_clr_i is sampled. When a trigger and a clear come in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Base trigger |
| scan_done_i | input | 1 | Input scan complete |
| alg_done_i | input | 1 | Current algorithm slot complete |
| out_done_i | input | 1 | Output write complete |
| alg_mask_i | input | NUM_SLOTS | Slot enable mask, bit k for slot k |
| status_vars_i | input | NVAR_W | Count of referenced status variables |
| win_len_i | input | WIN_W | Update window length in cycles |
| overrun_clr_i | input | 1 | Write-one-to-clear for overrun_o |
| scan_start_o | output | 1 | Input scan start strobe |
| verify_start_o | output | 1 | Status check start strobe |
| update_start_o | output | 1 | Update window start strobe |
| alg_start_o | output | 1 | Algorithm slot start strobe |
| out_start_o | output | 1 | Output write start strobe |
| alg_idx_o | output | $clog2(NUM_SLOTS) | Index of current or last slot |
| busy_o | output | 1 | Cycle in progress |
| overrun_o | output | 1 | Sticky trigger-overrun flag |

## Verification
A corrupted phase state shows at the ports within one handshake. A strobe appears out of order, or the block stops waiting for the done it expects. The bench therefore measures the distance between strobes in cycles. An off-by-one timer load moves update_start_o or the first slot start by one cycle, and the cycle after the check or the window shows it. A wrong slot search shows as an alg_idx_o that is not the next set bit of the mask, or as an out_start_o that arrives while enabled slots are still left.

// File: rtl/scan_cycle_seq_pkg.sv
// Shared types for the scan-execute cycle sequencer.
// Assumes nothing beyond one enum holding the phase state.
package scan_cycle_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_VERIFY,
        ST_UPDATE,
        ST_ALG,
        ST_OUT
    } cyc_state_t;
endpackage

// File: rtl/cyc_tick_timer.sv
// Down-counter for the internally timed phases.
// A load sets the count to (length - 1). The count steps down while run_i is high,
// and zero_o marks the last cycle of the phase. A load overrides run.
module cyc_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load a new phase length, or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cyc_slot_pick.sv
// Finds the lowest enabled slot whose index is at or above from_i.
// Purely combinational. A from_i equal to N means no slot is left.
module cyc_slot_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0] mask_i,
    input  logic [IW:0]  from_i,
    output logic         found_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top slot down so that the lowest match is the one kept.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mask_i[k] && ((IW+1)'(k) >= from_i)) begin
                found_o = 1'b1;
                idx_o   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/scan_cycle_seq.sv
// Top of the cycle sequencer. It runs scan, an optional timed status check, a timed update
// window, the enabled slots in ascending order, and the output write, once per base trigger.
// Assumes each done input is a pulse given only while its phase is active.
module scan_cycle_seq
    import scan_cycle_seq_pkg::*;
#(
    parameter int NUM_SLOTS      = 32,
    parameter int NVAR_W         = 8,
    parameter int WIN_W          = 16,
    parameter int VERIFY_BASE    = 23,
    parameter int VERIFY_PER_VAR = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_i,
    input  logic                         scan_done_i,
    input  logic                         alg_done_i,
    input  logic                         out_done_i,
    input  logic [NUM_SLOTS-1:0]         alg_mask_i,
    input  logic [NVAR_W-1:0]            status_vars_i,
    input  logic [WIN_W-1:0]             win_len_i,
    input  logic                         overrun_clr_i,
    output logic                         scan_start_o,
    output logic                         verify_start_o,
    output logic                         update_start_o,
    output logic                         alg_start_o,
    output logic                         out_start_o,
    output logic [$clog2(NUM_SLOTS)-1:0] alg_idx_o,
    output logic                         busy_o,
    output logic                         overrun_o
);
    localparam int IDX_W   = $clog2(NUM_SLOTS);
    localparam int VER_MAX = VERIFY_BASE + VERIFY_PER_VAR * ((1 << NVAR_W) - 1);
    localparam int VER_W   = $clog2(VER_MAX + 1);
    localparam int TMR_W   = (VER_W > WIN_W) ? VER_W : WIN_W;

    cyc_state_t       state_q, state_nxt;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    logic             enter;
    logic             tmr_load, tmr_zero, tmr_run;
    logic [TMR_W-1:0] tmr_val, ver_len, win_val;
    logic [IDX_W:0]   pick_from;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    // Phase lengths expressed as timer load values (length - 1).
    assign ver_len = TMR_W'(VERIFY_BASE) + TMR_W'(VERIFY_PER_VAR) * TMR_W'(status_vars_i);
    assign win_val = (win_len_i == '0) ? '0 : TMR_W'(win_len_i) - 1'b1;
    assign tmr_run = (state_q == ST_VERIFY) || (state_q == ST_UPDATE);

    cyc_tick_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .zero_o     (tmr_zero)
    );

    cyc_slot_pick #(.N(NUM_SLOTS), .IW(IDX_W)) u_pick (
        .mask_i  (alg_mask_i),
        .from_i  (pick_from),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // Next-phase decision, timer loads and slot search origin.
    always_comb begin
        state_nxt = state_q;
        idx_nxt   = idx_q;
        enter     = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        pick_from = '0;
        case (state_q)
            ST_IDLE: if (trig_i) begin
                state_nxt = ST_SCAN;
                enter     = 1'b1;
            end
            ST_SCAN: if (scan_done_i) begin
                enter    = 1'b1;
                tmr_load = 1'b1;
                if (status_vars_i != '0) begin
                    state_nxt = ST_VERIFY;
                    tmr_val   = ver_len - 1'b1;
                end else begin
                    state_nxt = ST_UPDATE;
                    tmr_val   = win_val;
                end
            end
            ST_VERIFY: if (tmr_zero) begin
                state_nxt = ST_UPDATE;
                enter     = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = win_val;
            end
            ST_UPDATE: begin
                pick_from = '0;
                if (tmr_zero) begin
                    enter     = 1'b1;
                    state_nxt = pick_found ? ST_ALG : ST_OUT;
                    idx_nxt   = pick_found ? pick_idx : idx_q;
                end
            end
            ST_ALG: begin
                pick_from = {1'b0, idx_q} + 1'b1;
                if (alg_done_i) begin
                    enter     = 1'b1;
                    state_nxt = pick_found ? ST_ALG : ST_OUT;
                    idx_nxt   = pick_found ? pick_idx : idx_q;
                end
            end
            ST_OUT: if (out_done_i) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Phase state and current slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nxt;
            idx_q   <= idx_nxt;
        end
    end

    // One-cycle start strobe in the first cycle of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_start_o   <= 1'b0;
            verify_start_o <= 1'b0;
            update_start_o <= 1'b0;
            alg_start_o    <= 1'b0;
            out_start_o    <= 1'b0;
        end else begin
            scan_start_o   <= enter && (state_nxt == ST_SCAN);
            verify_start_o <= enter && (state_nxt == ST_VERIFY);
            update_start_o <= enter && (state_nxt == ST_UPDATE);
            alg_start_o    <= enter && (state_nxt == ST_ALG);
            out_start_o    <= enter && (state_nxt == ST_OUT);
        end
    end

    // Sticky overrun: a trigger while busy sets it, the clear input drops it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                            overrun_o <= 1'b0;
        else if (trig_i && state_q != ST_IDLE) overrun_o <= 1'b1;
        else if (overrun_clr_i)                overrun_o <= 1'b0;
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign alg_idx_o = idx_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scan_start_o, verify_start_o, update_start_o, alg_start_o, out_start_o})); // R2
    AST_SKIP_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && scan_done_i && status_vars_i == '0) |=> update_start_o); // R3
    AST_ALG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_start_o && $past(state_q) == ST_ALG) |-> (alg_idx_o > $past(alg_idx_o))); // R6
    AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && state_nxt == ST_ALG) |-> alg_mask_i[pick_idx]); // R7
    AST_IDLE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUT && out_done_i) |=> !busy_o); // R9
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> (overrun_o && !scan_start_o)); // R10
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !overrun_clr_i) |=> overrun_o); // R10
endmodule

// File: tb/scan_cycle_seq_tb.sv
module scan_cycle_seq_tb;
    localparam int BASE = 23;
    localparam int PER  = 4;
    localparam int NV   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 0, sdone = 0, adone = 0, odone = 0, oclr = 0;
    logic [31:0] mask = '0;
    logic [7:0]  nvars = '0;
    logic [15:0] win = '0;
    logic        s_scan, s_ver, s_upd, s_alg, s_out, busy, ovr;
    logic [4:0]  idx;
    int          n_chk = 0, n_bad = 0;

    localparam logic [31:0] V_MASK [NV] = '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                                            32'h0000_0000, 32'hA5A5_0F0F, 32'h0001_8000};
    localparam logic [7:0]  V_NV   [NV] = '{8'd0, 8'd1, 8'd0, 8'd2, 8'd5, 8'd0};
    localparam logic [15:0] V_WIN  [NV] = '{16'd3, 16'd0, 16'd1, 16'd5, 16'd2, 16'd7};

    always #10 clk = ~clk;

    scan_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .scan_done_i(sdone), .alg_done_i(adone),
        .out_done_i(odone), .alg_mask_i(mask), .status_vars_i(nvars), .win_len_i(win),
        .overrun_clr_i(oclr), .scan_start_o(s_scan), .verify_start_o(s_ver),
        .update_start_o(s_upd), .alg_start_o(s_alg), .out_start_o(s_out),
        .alg_idx_o(idx), .busy_o(busy), .overrun_o(ovr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one triggered cycle, answering every start strobe at once, and times the strobes.
    task automatic run_vec(input logic [31:0] m, input logic [7:0] n, input logic [15:0] w);
        int t = 0, t_scan = 0, t_ver = 0, t_upd = 0, t_out = -1, nxt = 0, n_alg = 0;
        int ew = (w == 0) ? 1 : int'(w);
        @(negedge clk);
        mask = m; nvars = n; win = w; trig = 1;
        @(negedge clk);
        trig = 0;
        chk("R2 scan strobe", int'(s_scan), 1);
        chk("R2 busy", int'(busy), 1);
        while (t < 3000) begin
            sdone = 0; adone = 0; odone = 0;
            if (s_scan) begin t_scan = t; sdone = 1; end
            if (s_ver) begin t_ver = t; chk("R4 check start", t_ver - t_scan, 1); end
            if (s_upd) begin
                t_upd = t;
                if (n == 0) chk("R3 skip check", t_upd - t_scan, 1);
                else chk("R4 check length", t_upd - t_ver, BASE + PER * int'(n));
            end
            if (s_alg) begin
                int e = -1;
                for (int k = 31; k >= nxt; k--) if (m[k]) e = k;
                if (n_alg == 0) chk("R5 window", t - t_upd, ew);
                chk("R6 R7 slot order", int'(idx), e);
                nxt = int'(idx) + 1; n_alg++; adone = 1;
            end
            if (s_out) begin
                int left = 0;
                for (int k = 31; k >= nxt; k--) if (m[k]) left++;
                chk("R7 no slot left", left, 0);
                if (n_alg == 0) chk("R8 R5 direct out", t - t_upd, ew);
                t_out = t; odone = 1;
            end
            if (t_out >= 0 && t == t_out + 1) begin
                chk("R9 idle", int'(busy), 0);
                break;
            end
            @(negedge clk);
            t++;
        end
        sdone = 0; adone = 0; odone = 0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 strobes in reset", int'({s_scan, s_ver, s_upd, s_alg, s_out}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 overrun after reset", int'(ovr), 0);
        chk("R1 busy after reset", int'(busy), 0);

        for (int v = 0; v < NV; v++) run_vec(V_MASK[v], V_NV[v], V_WIN[v]);

        // R10: trigger while busy is ignored and sets overrun; then clear and set-wins
        mask = '0; nvars = '0; win = 16'd1;
        trig = 1; @(negedge clk); trig = 0;
        @(negedge clk);
        trig = 1; @(negedge clk); trig = 0;
        chk("R10 overrun set", int'(ovr), 1);
        chk("R10 no new scan", int'(s_scan), 0);
        chk("R10 still busy", int'(busy), 1);
        trig = 1; oclr = 1; @(negedge clk); trig = 0; oclr = 0;
        chk("R10 set wins", int'(ovr), 1);
        @(negedge clk);
        chk("R10 sticky", int'(ovr), 1);
        oclr = 1; @(negedge clk); oclr = 0;
        chk("R10 cleared", int'(ovr), 0);
        // finish the cycle: scan done, 1-cycle window, empty mask
        sdone = 1; @(negedge clk); sdone = 0;
        chk("R3 update strobe", int'(s_upd), 1);
        @(negedge clk);
        chk("R8 out strobe", int'(s_out), 1);
        odone = 1; @(negedge clk); odone = 0;
        chk("R9 idle after out", int'(busy), 0);

        // R1: reset in mid-cycle returns to idle
        trig = 1; @(negedge clk); trig = 0;
        rst_n = 0; @(negedge clk);
        chk("R1 mid-cycle reset", int'(busy), 0);
        rst_n = 1; @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule